// File: doc/BRIEF.md
# Two-Bank Interrupt Controller

This block gathers 64 interrupt lines into two banks of 32 and drives one interrupt request to the processor. Each bank holds a latched event vector, an enable mask and the live level of its lines, plus a fixed set of lines that act on level instead of edge. Software reaches the banks through a simple 32-bit register bus. The bus decodes the low 12 bits of a 4 KiB window. Software can read events, mask and levels, write the mask, and clear latched events.

Inputs are sampled on the clock. A rising edge of a sampled input latches an event, except on level-sensitive lines. Level-sensitive lines request an interrupt for as long as they are high and enabled. The processor request is registered and follows any change in one clock.

Top module: `dual_bank_intc`

## Requirements
- R1: The bank slot is (bus_addr - 0x010) >> 4 on 12 bits. Slot 0 (0x010-0x01F) is bank 0 and slot 1 (0x020-0x02F) is bank 1. Any other slot, including addresses below 0x010, reads as zero and ignores writes.
- R2: The low four address bits select the register inside a bank: 0x0 reads the events, 0x4 reads and writes the mask, 0x8 is the write-only clear, and 0xC reads the live levels. Any other offset, and a read of 0x8, returns zero, and writes to other offsets are ignored.
- R3: Input lines 0-31 feed bank 1 and lines 32-63 feed bank 0, at bit position line mod 32.
- R4: A sampled input that rises sets its level bit and, unless the line is level-sensitive, its event bit. A falling input clears only its level bit. An event cleared while its input stays high is not set again until the input falls and rises again.
- R5: Writing the clear register clears every event bit written as 1. Bits on level-sensitive lines are not affected.
- R6: After reset bank 0 has no level-sensitive lines. Bank 1 has level-sensitive mask 0x1FF00000 (bits 20-28). These lines never set event bits, and they request while high and enabled.
- R7: cpu_irq is the OR over both banks of |((events | (levels & level_sensitive)) & mask). It is registered and changes at the same clock edge that samples the input change, the mask write or the clear write.
- R8: A mask write takes effect at once: an event that was pending while masked raises cpu_irq at the edge of the write.
- R9: If a rising input and a clear write hit the same event bit in the same cycle, the bit stays set.
- R10: Synchronous active-high reset clears events, masks, levels, cpu_irq and bus_rdata.
- R11: Read data appears on bus_rdata at the clock edge that samples bus_rd. It holds its value while bus_rd is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 64 | Interrupt input lines |
| bus_addr | input | 12 | Register address inside the 4 KiB window |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| cpu_irq | output | 1 | Registered processor interrupt request |

## Verification
The edge latch and the software clear can act on the same event bit in one cycle. The bench provokes this by raising input line 0 on the same clock on which it writes a 1 to bank 1's clear register. It judges the outcome by reading bank 1's event register, which must still show bit 0. The bench also covers a related pair: a mask write that meets an event already latched. It checks that cpu_irq rises at the edge of that very write.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int BANK_W    = 32;
    localparam int NUM_BANKS = 2;
    localparam int ADDR_W    = 12;
    localparam int SLOT_SH   = 4;
    localparam logic [ADDR_W-1:0] BANK_BASE = 12'h010;

    typedef enum logic [3:0] {
        OFS_EVENT = 4'h0,
        OFS_MASK  = 4'h4,
        OFS_CLEAR = 4'h8,
        OFS_LEVEL = 4'hC
    } reg_ofs_e;

    typedef struct packed {
        logic [BANK_W-1:0] events;
        logic [BANK_W-1:0] mask;
        logic [BANK_W-1:0] levels;
    } bank_view_t;

    typedef struct packed {
        logic mask_we;
        logic clr_we;
    } bank_ctl_t;

    // Fixed level-sensitive lines of each bank, applied at reset
    function automatic logic [BANK_W-1:0] level_lines(input int bank);
        logic [BANK_W-1:0] m;
        m = '0;
        if (bank == 1) m = BANK_W'(32'h1FF0_0000);
        return m;
    endfunction

    function automatic logic [ADDR_W-1:0] bank_slot(input logic [ADDR_W-1:0] addr);
        return (addr - BANK_BASE) >> SLOT_SH;
    endfunction

endpackage

// File: rtl/irqc_bank.sv
module irqc_bank
    import irqc_pkg::*;
#(
    parameter int              W  = BANK_W,
    parameter logic [W-1:0]    LS = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] lines,
    input  logic         mask_we,
    input  logic         clr_we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] ev_q,
    output logic [W-1:0] mask_q,
    output logic [W-1:0] lv_q,
    output logic         req_now,
    output logic         req_next
);

    logic [W-1:0] rise;
    logic [W-1:0] clr_bits;
    logic [W-1:0] ev_d;
    logic [W-1:0] mask_d;

    always_comb begin
        rise     = lines & ~lv_q;
        clr_bits = clr_we ? (wdata & ~LS) : '0;
        ev_d     = (ev_q & ~clr_bits) | (rise & ~LS);
        mask_d   = mask_we ? wdata : mask_q;
        req_next = |((ev_d | (lines & LS)) & mask_d);
        req_now  = |((ev_q | (lv_q & LS)) & mask_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ev_q   <= '0;
            mask_q <= '0;
            lv_q   <= '0;
        end else begin
            ev_q   <= ev_d;
            mask_q <= mask_d;
            lv_q   <= lines;
        end
    end

    // R4: an event bit only appears where a rising edge was seen
    p_edge_only_r4: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((ev_q & ~$past(ev_q) & ~$past(rise)) == '0));

    // R6: level-sensitive lines never hold an event
    p_ls_no_event_r6: assert property (@(posedge clk) disable iff (rst)
        (ev_q & LS) == '0);

    // R5: cleared bits are gone unless an edge refilled them
    p_clear_r5: assert property (@(posedge clk) disable iff (rst)
        clr_we |=> ((ev_q & $past(wdata & ~LS & ~rise)) == '0));

    // R9: rising edge beats a clear on the same bit
    p_rise_wins_r9: assert property (@(posedge clk) disable iff (rst)
        (clr_we && |(rise & wdata & ~LS)) |=>
        ((ev_q & $past(rise & wdata & ~LS)) == $past(rise & wdata & ~LS)));

endmodule

// File: rtl/irqc_regif.sv
module irqc_regif
    import irqc_pkg::*;
#(
    parameter int NB = NUM_BANKS
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic                       bus_wr,
    input  logic                       bus_rd,
    input  bank_view_t [NB-1:0]        views,
    output bank_ctl_t  [NB-1:0]        ctl,
    output logic [BANK_W-1:0]          bus_rdata
);

    logic [ADDR_W-1:0] slot;
    logic              slot_ok;
    reg_ofs_e          ofs;
    logic [BANK_W-1:0] rd_val;

    assign slot    = bank_slot(bus_addr);
    assign slot_ok = slot < ADDR_W'(NB);
    assign ofs     = reg_ofs_e'(bus_addr[3:0]);

    for (genvar b = 0; b < NB; b++) begin : g_ctl
        logic hit;
        assign hit           = bus_wr && slot_ok && (slot == ADDR_W'(b));
        assign ctl[b].mask_we = hit && (ofs == OFS_MASK);
        assign ctl[b].clr_we  = hit && (ofs == OFS_CLEAR);
    end

    always_comb begin
        rd_val = '0;
        for (int b = 0; b < NB; b++) begin
            if (slot_ok && slot == ADDR_W'(b)) begin
                case (ofs)
                    OFS_EVENT: rd_val = views[b].events;
                    OFS_MASK:  rd_val = views[b].mask;
                    OFS_LEVEL: rd_val = views[b].levels;
                    default:   rd_val = '0;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)         bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_val;
    end

    // R1: reads outside the bank slots return zero
    p_bad_slot_zero_r1: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && !slot_ok) |=> (bus_rdata == '0));

    // R11: read data holds between reads
    p_rdata_hold_r11: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> $stable(bus_rdata));

endmodule

// File: rtl/dual_bank_intc.sv
module dual_bank_intc
    import irqc_pkg::*;
#(
    parameter int NB = NUM_BANKS,
    parameter int W  = BANK_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NB*W-1:0]     irq_in,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [W-1:0]        bus_wdata,
    output logic [W-1:0]        bus_rdata,
    output logic                cpu_irq
);

    bank_view_t [NB-1:0] views;
    bank_ctl_t  [NB-1:0] ctl;
    logic       [NB-1:0] req_now;
    logic       [NB-1:0] req_next;

    irqc_regif #(.NB(NB)) u_regif (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .views     (views),
        .ctl       (ctl),
        .bus_rdata (bus_rdata)
    );

    // Banks take the input lines in reverse order: the last bank gets lines 0..W-1
    for (genvar b = 0; b < NB; b++) begin : g_bank
        irqc_bank #(.W(W), .LS(level_lines(b))) u_bank (
            .clk      (clk),
            .rst      (rst),
            .lines    (irq_in[(NB-1-b)*W +: W]),
            .mask_we  (ctl[b].mask_we),
            .clr_we   (ctl[b].clr_we),
            .wdata    (bus_wdata),
            .ev_q     (views[b].events),
            .mask_q   (views[b].mask),
            .lv_q     (views[b].levels),
            .req_now  (req_now[b]),
            .req_next (req_next[b])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) cpu_irq <= 1'b0;
        else     cpu_irq <= |req_next;
    end

    // R7: registered output equals the OR of the bank requests from stored state
    p_irq_match_r7: assert property (@(posedge clk) disable iff (rst)
        cpu_irq == (|req_now));

endmodule

// File: tb/dual_bank_intc_test.sv
`timescale 1ns/1ps
module dual_bank_intc_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] irq_in = '0;
    logic [11:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        cpu_irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic        rd_seen = 1'b0;

    always #2.5 clk = ~clk;

    dual_bank_intc uut (
        .clk(clk), .rst(rst), .irq_in(irq_in), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .cpu_irq(cpu_irq)
    );

    always @(posedge clk) rd_seen <= bus_rd;

    // Monitor: compare each read result against the scoreboard
    initial begin
        forever begin
            @(negedge clk);
            if (rd_seen && exp_q.size() > 0) begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                checks++;
                if (bus_rdata !== e) begin
                    failures++;
                    $display("FAIL %s rdata actual=%08h expected=%08h", t, bus_rdata, e);
                end
            end
        end
    end

    task automatic rd(input logic [11:0] a, input logic [31:0] e, input string t);
        @(negedge clk);
        bus_addr = a;
        bus_rd = 1'b1;
        exp_q.push_back(e);
        tag_q.push_back(t);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        bus_wdata = d;
        bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic set_line(input int n, input logic v);
        @(negedge clk);
        irq_in[n] = v;
        @(negedge clk);
    endtask

    task automatic chk_irq(input logic e, input string t);
        checks++;
        if (cpu_irq !== e) begin
            failures++;
            $display("FAIL %s cpu_irq actual=%0b expected=%0b", t, cpu_irq, e);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        chk_irq(1'b0, "R10");
        rd(12'h010, 32'h0, "R10 events");
        rd(12'h014, 32'h0, "R10 mask");
        rd(12'h02C, 32'h0, "R10 levels");

        // R3/R4: line 35 lands in bank 0 bit 3
        set_line(35, 1'b1);
        rd(12'h01C, 32'h0000_0008, "R3 bank0 level");
        rd(12'h010, 32'h0000_0008, "R4 bank0 event");
        rd(12'h020, 32'h0, "R3 bank1 untouched");
        chk_irq(1'b0, "R7 masked");

        // R8: enabling a pending event raises the output at the write edge
        wr(12'h014, 32'h0000_0008);
        chk_irq(1'b1, "R8");

        // R4: falling input clears level only
        set_line(35, 1'b0);
        rd(12'h01C, 32'h0, "R4 level cleared");
        rd(12'h010, 32'h0000_0008, "R4 event kept");
        chk_irq(1'b1, "R4 latched");

        // R5: clear
        wr(12'h018, 32'h0000_0008);
        chk_irq(1'b0, "R5 clear drops irq");
        rd(12'h010, 32'h0, "R5 event cleared");

        // R6: bank 1 bit 20 is level-sensitive
        set_line(20, 1'b1);
        rd(12'h02C, 32'h0010_0000, "R6 level");
        rd(12'h020, 32'h0, "R6 no event");
        wr(12'h024, 32'h0010_0000);
        chk_irq(1'b1, "R6 level request");
        wr(12'h028, 32'h0010_0000);
        chk_irq(1'b1, "R5 clear ignores level line");
        rd(12'h020, 32'h0, "R5 level line event");
        set_line(20, 1'b0);
        chk_irq(1'b0, "R6 level drop");

        // R6: bank 0 bit 20 (line 52) is edge-triggered
        set_line(52, 1'b1);
        rd(12'h010, 32'h0010_0000, "R6 bank0 edge");
        set_line(52, 1'b0);
        wr(12'h018, 32'h0010_0000);
        rd(12'h010, 32'h0, "R5 bank0 cleared");

        // R4: no re-latch while input stays high
        set_line(0, 1'b1);
        rd(12'h020, 32'h0000_0001, "R4 bank1 edge");
        wr(12'h028, 32'h0000_0001);
        repeat (3) @(negedge clk);
        rd(12'h020, 32'h0, "R4 no relatch while high");
        set_line(0, 1'b0);
        set_line(0, 1'b1);
        rd(12'h020, 32'h0000_0001, "R4 new edge");

        // R9: edge and clear in the same cycle
        set_line(0, 1'b0);
        wr(12'h028, 32'h0000_0001);
        rd(12'h020, 32'h0, "R9 precondition");
        @(negedge clk);
        irq_in[0] = 1'b1;
        bus_addr = 12'h028;
        bus_wdata = 32'h0000_0001;
        bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        rd(12'h020, 32'h0000_0001, "R9 edge wins");

        // R1: bad slots
        wr(12'h034, 32'hFFFF_FFFF);
        wr(12'h004, 32'hFFFF_FFFF);
        rd(12'h034, 32'h0, "R1 slot2 reads zero");
        rd(12'h004, 32'h0, "R1 underflow reads zero");
        rd(12'h014, 32'h0000_0008, "R1 bank0 mask unchanged");
        rd(12'h024, 32'h0010_0000, "R1 bank1 mask unchanged");

        // R2: offsets
        wr(12'h016, 32'hFFFF_FFFF);
        rd(12'h014, 32'h0000_0008, "R2 odd offset write ignored");
        rd(12'h028, 32'h0, "R2 clear reads zero");
        rd(12'h021, 32'h0, "R2 odd offset reads zero");

        // R11: hold
        rd(12'h024, 32'h0010_0000, "R11 read");
        bus_addr = 12'h020;
        repeat (3) @(negedge clk);
        checks++;
        if (bus_rdata !== 32'h0010_0000) begin
            failures++;
            $display("FAIL R11 hold actual=%08h expected=%08h", bus_rdata, 32'h0010_0000);
        end

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule